// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block writes one received Ethernet frame at a time into host memory. A frame is announced with a start pulse and its byte count. Its bytes then arrive one per handshake on a byte stream. The engine follows a list of four-word receive descriptors in host memory. It reads each descriptor and checks that the engine owns it. It then scatters the frame bytes into the one or two data buffers that the descriptor names. After that it writes a status word back into the descriptor and moves its current-descriptor pointer on to the next entry. The list can be a ring that wraps to a base address, or a chain in which each entry holds the address of the next one.

All memory traffic goes through one word-wide request port. The port has a request and an acknowledge, a write enable and per-byte enables. Frame bytes are packed little-endian into 32-bit words, and a partial last word in a buffer is written with only its valid byte lanes enabled. The engine reports a receive-state code and two one-cycle event pulses to a separate status block. One pulse marks a completed frame (receive interrupt). The other marks a descriptor that is not available (receive unavailable). Software clears ownership and interrupt status elsewhere. This block only sets them.

Top module: `rx_desc_dma`

## Requirements
- R1: When a frame starts while the current-descriptor pointer `desc_ptr` is zero, the pointer is first loaded from `cfg_base`, and the first descriptor is read from that address.
- R2: If descriptor word 0 bit 31 (ownership, 1 = engine) is 0 on the first descriptor of a frame, then `ev_ri` and `ev_ru` pulse together for one cycle and `rx_state` becomes 4 (suspended). No memory write is made, the frame bytes are accepted and discarded, and `desc_ptr` is unchanged.
- R3: The frame is stored as its announced byte count followed by four zero bytes that stand in for the frame check sequence, so the stored length is the announced length plus 4.
- R4: Buffer 1 takes up to word1[10:0] bytes at the address in word 2. If bytes remain and word1[24] (chained) is 0, buffer 2 takes up to word1[21:11] bytes at the address in word 3. A buffer of size 0 is skipped.
- R5: The next descriptor address is chosen in priority order. If word1[25] (end of ring) is set, it is `cfg_base`. Otherwise, if word1[24] is set, it is word 3. Otherwise it is the current address plus 16.
- R6: Write-back replaces word 0 only. Bit 31 is 0, bits [29:16] hold the running count of bytes stored for the frame up to and including this descriptor, bit 9 marks the frame's first descriptor and bit 8 its last, and all other bits are 0. Words 1 to 3 are not written.
- R7: If a frame continues into a descriptor that the engine does not own, that descriptor's word 0 is written with bit 8 set, bit 14 (error) set unless `cfg_flush` is 1, and the running count. The rest of the frame is discarded and `desc_ptr` moves past that descriptor.
- R8: At the end of a frame, `ev_ri` pulses once unless word1[31] of the last descriptor is set.
- R9: `rx_state` is 0 after reset. During a frame it shows 1 while a descriptor is read, 7 while data moves, and 5 while the final write-back is made. It shows 3 once the frame is done.
- R10: Frame bytes are packed little-endian (byte n of a buffer in lane n mod 4). Each buffer starts at its own word-aligned address. A partial word carries contiguous byte enables starting at lane 0.
- R11: A memory request keeps its address and direction unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Base address of the descriptor list |
| cfg_flush | input | 1 | Suppresses the error flag on a mid-frame unavailable descriptor |
| frm_start | input | 1 | Starts a frame; taken when `frm_idle` is 1 |
| frm_len | input | LW | Frame byte count excluding check sequence, 1 to 2^LW-5 |
| frm_idle | output | 1 | Engine ready for a new frame |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Frame byte accepted when high with `in_valid` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| desc_ptr | output | AW | Current descriptor address |
| rx_state | output | 3 | Receive state code |
| ev_ri | output | 1 | Frame-complete event pulse |
| ev_ru | output | 1 | Descriptor-unavailable event pulse |

## Verification
The bench goes after buffer sizes that are not multiples of four. A design that packs the byte lanes wrongly would spill into the byte after a buffer, or would lose the start of the next buffer. It sets up a frame that spans buffer 2 and a second descriptor, which catches a wrong running length or a misplaced first or last flag. It checks a descriptor flagged both end-of-ring and chained, which catches an inverted next-address priority. It also checks the pointer-zero start, since skipping it would read address zero. An unavailable descriptor is tested at the first position and in mid-frame, with and without the flush control, and the interrupt-disable bit is tested as well. A design that got these wrong would raise the unavailable event in the wrong case, corrupt memory, or give a wrong event count.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CHK, S_XFER, S_WR, S_NBUF, S_WB, S_DROP
  } fsm_t;

  localparam logic [2:0] CODE_STOP  = 3'd0;
  localparam logic [2:0] CODE_FETCH = 3'd1;
  localparam logic [2:0] CODE_WAIT  = 3'd3;
  localparam logic [2:0] CODE_SUSP  = 3'd4;
  localparam logic [2:0] CODE_CLOSE = 3'd5;
  localparam logic [2:0] CODE_XFER  = 3'd7;

  localparam int BUF_SZW  = 11;
  localparam int B_OWN    = 31;
  localparam int B_LEN_LO = 16;
  localparam int B_ERR    = 14;
  localparam int B_FIRST  = 9;
  localparam int B_LAST   = 8;
  localparam int B_SZ1_LO = 0;
  localparam int B_SZ2_LO = 11;
  localparam int B_CHAIN  = 24;
  localparam int B_EOR    = 25;
  localparam int B_NOIRQ  = 31;

endpackage

// File: rtl/rxd_next_addr.sv
module rxd_next_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  input  logic          eor,
  input  logic          chain,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STRIDE = AW'(16);

  always_comb begin
    if (eor)        nxt = base;
    else if (chain) nxt = link;
    else            nxt = cur + STRIDE;
  end
endmodule

// File: rtl/rxd_wb_fmt.sv
module rxd_wb_fmt #(
  parameter int LW = 14
) (
  input  logic [LW-1:0] len,
  input  logic          first,
  input  logic          last,
  input  logic          err,
  output logic [31:0]   word
);
  import rxd_pkg::*;

  always_comb begin
    word                 = '0;
    word[B_LEN_LO +: LW] = len;
    word[B_ERR]          = err;
    word[B_FIRST]        = first;
    word[B_LAST]         = last;
    word[B_OWN]          = 1'b0;
  end
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               clr,
  input  logic [7:0]         din,
  output logic [8*LANES-1:0] word,
  output logic [LANES-1:0]   be,
  output logic               top_lane
);
  localparam int LNW = $clog2(LANES);

  logic [LNW-1:0]     lane_q, lane_d;
  logic [8*LANES-1:0] word_q, word_d;
  logic [LANES-1:0]   be_q, be_d;
  logic [LANES-1:0]   hit;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign hit[g] = push && (lane_q == LNW'(g));
      always_comb begin
        word_d[8*g +: 8] = word_q[8*g +: 8];
        be_d[g]          = be_q[g];
        if (clr) begin
          word_d[8*g +: 8] = 8'h00;
          be_d[g]          = 1'b0;
        end else if (hit[g]) begin
          word_d[8*g +: 8] = din;
          be_d[g]          = 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    lane_d = lane_q;
    if (clr)       lane_d = '0;
    else if (push) lane_d = lane_q + LNW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      word_q <= '0;
      be_q   <= '0;
    end else begin
      lane_q <= lane_d;
      word_q <= word_d;
      be_q   <= be_d;
    end
  end

  assign word     = word_q;
  assign be       = be_q;
  assign top_lane = (lane_q == LNW'(LANES-1));

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !be_q[LANES-1]);  // R10
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int AW = 32,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_flush,
  input  logic          frm_start,
  input  logic [LW-1:0] frm_len,
  output logic          frm_idle,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] desc_ptr,
  output logic [2:0]    rx_state,
  output logic          ev_ri,
  output logic          ev_ru
);
  import rxd_pkg::*;

  localparam int SZW = BUF_SZW;
  localparam logic [AW-1:0]  WSTEP = AW'(4);
  localparam logic [LW-1:0]  FCS_B = LW'(4);
  localparam logic [LW-1:0]  L_ONE = LW'(1);
  localparam logic [SZW-1:0] S_ONE = SZW'(1);

  fsm_t           st_q, st_d;
  logic [AW-1:0]  dptr_q, dptr_d, waddr_q, waddr_d, b1a_q, b1a_d, link_q, link_d;
  logic [1:0]     rdi_q, rdi_d;
  logic           own_q, own_d, chain_q, chain_d, eor_q, eor_d, noirq_q, noirq_d;
  logic [SZW-1:0] sz1_q, sz1_d, sz2_q, sz2_d, left_q, left_d;
  logic           bsel_q, bsel_d;
  logic [LW-1:0]  flen_q, flen_d, total_q, total_d, cnt_q, cnt_d, taken_q, taken_d;
  logic           first_q, first_d, fin_q, fin_d, err_q, err_d;
  logic [2:0]     code_q, code_d;
  logic           ri_q, ri_d, ru_q, ru_d;

  logic           src_strm, byte_ok, pk_push, pk_clr, pk_top;
  logic [7:0]     pk_byte;
  logic [31:0]    pk_word, wb_word;
  logic [3:0]     pk_be;
  logic [AW-1:0]  nxt_addr;
  logic           unused_rd;

  assign src_strm  = (taken_q < flen_q);
  assign byte_ok   = src_strm ? in_valid : 1'b1;
  assign pk_byte   = src_strm ? in_data : 8'h00;
  assign unused_rd = ^mem_rdata;

  rxd_packer #(.LANES(4)) u_pack (
    .clk(clk), .rst_n(rst_n), .push(pk_push), .clr(pk_clr), .din(pk_byte),
    .word(pk_word), .be(pk_be), .top_lane(pk_top)
  );

  rxd_next_addr #(.AW(AW)) u_next (
    .cur(dptr_q), .base(cfg_base), .link(link_q), .eor(eor_q), .chain(chain_q),
    .nxt(nxt_addr)
  );

  rxd_wb_fmt #(.LW(LW)) u_fmt (
    .len(cnt_q), .first(first_q), .last(fin_q), .err(err_q), .word(wb_word)
  );

  always_comb begin
    st_d = st_q;     dptr_d = dptr_q;   waddr_d = waddr_q; b1a_d = b1a_q;
    link_d = link_q; rdi_d = rdi_q;     own_d = own_q;     chain_d = chain_q;
    eor_d = eor_q;   noirq_d = noirq_q; sz1_d = sz1_q;     sz2_d = sz2_q;
    left_d = left_q; bsel_d = bsel_q;   flen_d = flen_q;   total_d = total_q;
    cnt_d = cnt_q;   taken_d = taken_q; first_d = first_q; fin_d = fin_q;
    err_d = err_q;   code_d = code_q;   ri_d = 1'b0;       ru_d = 1'b0;
    pk_push = 1'b0;  pk_clr = 1'b0;
    unique case (st_q)
      S_IDLE: if (frm_start) begin
        flen_d  = frm_len;
        total_d = frm_len + FCS_B;
        cnt_d   = '0;
        taken_d = '0;
        first_d = 1'b1;
        fin_d   = 1'b0;
        err_d   = 1'b0;
        rdi_d   = '0;
        if (dptr_q == '0) dptr_d = cfg_base;
        code_d  = CODE_FETCH;
        st_d    = S_RD;
      end
      S_RD: if (mem_ack) begin
        unique case (rdi_q)
          2'd0: own_d = mem_rdata[B_OWN];
          2'd1: begin
            sz1_d   = mem_rdata[B_SZ1_LO +: SZW];
            sz2_d   = mem_rdata[B_SZ2_LO +: SZW];
            chain_d = mem_rdata[B_CHAIN];
            eor_d   = mem_rdata[B_EOR];
            noirq_d = mem_rdata[B_NOIRQ];
          end
          2'd2: b1a_d  = mem_rdata[AW-1:0];
          default: link_d = mem_rdata[AW-1:0];
        endcase
        if (rdi_q == 2'd3) st_d = S_CHK;
        else rdi_d = rdi_q + 2'd1;
      end
      S_CHK: begin
        if (own_q) begin
          bsel_d  = 1'b0;
          waddr_d = b1a_q;
          left_d  = sz1_q;
          code_d  = CODE_XFER;
          st_d    = S_XFER;
        end else if (first_q) begin
          ri_d   = 1'b1;
          ru_d   = 1'b1;
          code_d = CODE_SUSP;
          st_d   = S_DROP;
        end else begin
          err_d  = !cfg_flush;
          fin_d  = 1'b1;
          code_d = CODE_CLOSE;
          st_d   = S_WB;
        end
      end
      S_XFER: begin
        if (left_q == '0) begin
          st_d = S_NBUF;
        end else if (byte_ok) begin
          pk_push = 1'b1;
          cnt_d   = cnt_q + L_ONE;
          left_d  = left_q - S_ONE;
          if (src_strm) taken_d = taken_q + L_ONE;
          if (pk_top || left_q == S_ONE || (cnt_q + L_ONE) == total_q) st_d = S_WR;
        end
      end
      S_WR: if (mem_ack) begin
        pk_clr  = 1'b1;
        waddr_d = waddr_q + WSTEP;
        if (cnt_q == total_q) begin
          fin_d  = 1'b1;
          code_d = CODE_CLOSE;
          st_d   = S_WB;
        end else if (left_q == '0) begin
          st_d = S_NBUF;
        end else begin
          st_d = S_XFER;
        end
      end
      S_NBUF: begin
        if (!bsel_q && !chain_q) begin
          bsel_d  = 1'b1;
          waddr_d = link_q;
          left_d  = sz2_q;
          st_d    = S_XFER;
        end else begin
          st_d = S_WB;
        end
      end
      S_WB: if (mem_ack) begin
        dptr_d = nxt_addr;
        if (fin_q) begin
          ri_d   = !noirq_q;
          code_d = CODE_WAIT;
          st_d   = S_DROP;
        end else begin
          first_d = 1'b0;
          rdi_d   = '0;
          code_d  = CODE_FETCH;
          st_d    = S_RD;
        end
      end
      S_DROP: begin
        if (!src_strm) st_d = S_IDLE;
        else if (in_valid) taken_d = taken_q + L_ONE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  dptr_q <= '0;   waddr_q <= '0;  b1a_q <= '0;
      link_q <= '0;    rdi_q <= '0;    own_q <= 1'b0;  chain_q <= 1'b0;
      eor_q <= 1'b0;   noirq_q <= 1'b0; sz1_q <= '0;   sz2_q <= '0;
      left_q <= '0;    bsel_q <= 1'b0; flen_q <= '0;   total_q <= '0;
      cnt_q <= '0;     taken_q <= '0;  first_q <= 1'b0; fin_q <= 1'b0;
      err_q <= 1'b0;   code_q <= CODE_STOP; ri_q <= 1'b0; ru_q <= 1'b0;
    end else begin
      st_q <= st_d;    dptr_q <= dptr_d; waddr_q <= waddr_d; b1a_q <= b1a_d;
      link_q <= link_d; rdi_q <= rdi_d; own_q <= own_d;   chain_q <= chain_d;
      eor_q <= eor_d;  noirq_q <= noirq_d; sz1_q <= sz1_d; sz2_q <= sz2_d;
      left_q <= left_d; bsel_q <= bsel_d; flen_q <= flen_d; total_q <= total_d;
      cnt_q <= cnt_d;  taken_q <= taken_d; first_q <= first_d; fin_q <= fin_d;
      err_q <= err_d;  code_q <= code_d; ri_q <= ri_d;    ru_q <= ru_d;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = 4'h0;
    unique case (st_q)
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = dptr_q + {{(AW-4){1'b0}}, rdi_q, 2'b00};
        mem_be   = 4'hF;
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = waddr_q;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dptr_q;
        mem_wdata = wb_word;
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  assign frm_idle = (st_q == S_IDLE);
  assign in_ready = src_strm && ((st_q == S_XFER && left_q != '0) || st_q == S_DROP);
  assign desc_ptr = dptr_q;
  assign rx_state = code_q;
  assign ev_ri    = ri_q;
  assign ev_ru    = ru_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R11
  AST_RU_WITH_RI: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ru |-> ev_ri);  // R2
  AST_RU_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ru |-> (rx_state == CODE_SUSP));  // R2
  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));  // R10
  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WB && mem_req) |-> !mem_wdata[B_OWN]);  // R6
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> (cnt_q <= total_q));  // R3
  AST_EOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WB && mem_ack && eor_q) |=> (desc_ptr == $past(cfg_base)));  // R5
endmodule

// File: tb/sim_rx_desc_dma.sv
module sim_rx_desc_dma;
  localparam int AW = 32;
  localparam int LW = 14;
  localparam logic [31:0] BASE = 32'h100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cfg_base;
  logic          cfg_flush;
  logic          frm_start;
  logic [LW-1:0] frm_len;
  logic          frm_idle;
  logic          in_valid;
  logic [7:0]    in_data;
  logic          in_ready;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [3:0]    mem_be;
  logic [AW-1:0] desc_ptr;
  logic [2:0]    rx_state;
  logic          ev_ri, ev_ru;

  always #5 clk = ~clk;

  rx_desc_dma #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_flush(cfg_flush),
    .frm_start(frm_start), .frm_len(frm_len), .frm_idle(frm_idle),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .desc_ptr(desc_ptr), .rx_state(rx_state), .ev_ri(ev_ri), .ev_ru(ev_ru)
  );

  logic [31:0] mem  [0:1023];
  logic [31:0] emem [0:1023];
  logic [7:0]  fdata [0:63];
  int checks = 0, errors = 0;
  int ri_cnt = 0, ru_cnt = 0, exp_ri = 0, exp_ru = 0;
  logic [31:0] exp_ptr;
  logic [2:0]  exp_state;
  logic [7:0]  seen;

  // memory model with random acknowledge latency
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && ($urandom_range(0, 2) != 0)) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (ev_ri) ri_cnt++;
      if (ev_ru) ru_cnt++;
      seen[rx_state] = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setd(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                      input logic [31:0] w2, input logic [31:0] w3);
    mem[a[11:2]]      = w0;  emem[a[11:2]]      = w0;
    mem[a[11:2] + 1]  = w1;  emem[a[11:2] + 1]  = w1;
    mem[a[11:2] + 2]  = w2;  emem[a[11:2] + 2]  = w2;
    mem[a[11:2] + 3]  = w3;  emem[a[11:2] + 3]  = w3;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] p, input logic [31:0] w1,
                                      input logic [31:0] w3);
    if (w1[25]) return BASE;
    if (w1[24]) return w3;
    return p + 32'd16;
  endfunction

  // reference model built from the requirements
  task automatic ref_frame(input int len);
    logic [31:0] p, d0, d1, d2, d3, a;
    int cnt, total, sz;
    bit first, fin;
    p = (exp_ptr == 0) ? BASE : exp_ptr;
    first = 1; cnt = 0; total = len + 4;
    forever begin
      d0 = emem[p[11:2]]; d1 = emem[p[11:2] + 1];
      d2 = emem[p[11:2] + 2]; d3 = emem[p[11:2] + 3];
      if (!d0[31]) begin
        if (first) begin
          exp_ru++; exp_ri++; exp_state = 3'd4; exp_ptr = p;
          return;
        end
        emem[p[11:2]] = (32'(cnt) << 16) | 32'h100 | (cfg_flush ? 32'h0 : 32'h4000);
        if (!d1[31]) exp_ri++;
        exp_ptr = nxt(p, d1, d3); exp_state = 3'd3;
        return;
      end
      for (int b = 0; b < 2; b++) begin
        if (b == 1 && d1[24]) break;
        sz = (b == 1) ? int'(d1[21:11]) : int'(d1[10:0]);
        a  = (b == 1) ? d3 : d2;
        for (int k = 0; k < sz && cnt < total; k++) begin
          logic [31:0] ba;
          ba = a + 32'(k);
          emem[ba[11:2]][8*ba[1:0] +: 8] = (cnt < len) ? fdata[cnt] : 8'h00;
          cnt++;
        end
      end
      fin = (cnt == total);
      emem[p[11:2]] = (32'(cnt) << 16) | (first ? 32'h200 : 32'h0) | (fin ? 32'h100 : 32'h0);
      exp_ptr = nxt(p, d1, d3); p = exp_ptr;
      if (fin) begin
        if (!d1[31]) exp_ri++;
        exp_state = 3'd3;
        return;
      end
      first = 0;
    end
  endtask

  task automatic run_frame(input int len, input bit normal);
    int idx, bad;
    for (int i = 0; i < 64; i++) fdata[i] = 8'($urandom);
    ref_frame(len);
    @(negedge clk);
    seen = '0;
    frm_start = 1'b1; frm_len = LW'(len);
    @(negedge clk);
    frm_start = 1'b0;
    idx = 0;
    forever begin
      if (frm_idle) break;
      in_valid = ($urandom_range(0, 3) != 0) && (idx < len);
      in_data  = (idx < len) ? fdata[idx] : 8'h00;
      #1;
      if (in_valid && in_ready) idx++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    bad = -1;
    for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] !== emem[i]) bad = i;
    if (bad < 0) chk(1, "R3 R4 R10 R11", "memory image", 0, 0);
    else chk(0, "R3 R4 R10 R11", $sformatf("memory word %0d", bad), mem[bad], emem[bad]);
    chk(desc_ptr === exp_ptr, "R1 R5", "descriptor pointer", desc_ptr, exp_ptr);
    chk(ri_cnt == exp_ri, "R8", "completion events", ri_cnt, exp_ri);
    chk(ru_cnt == exp_ru, "R2", "unavailable events", ru_cnt, exp_ru);
    chk(rx_state === exp_state, "R9", "state code", {29'd0, rx_state}, {29'd0, exp_state});
    if (normal) chk(seen[1] && seen[7] && seen[5], "R9", "codes 1/7/5 seen", {24'd0, seen}, 32'hA2);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    rst_n = 1'b0; cfg_base = BASE; cfg_flush = 1'b0; frm_start = 1'b0;
    frm_len = '0; in_valid = 1'b0; in_data = 8'h00; mem_rdata = '0;
    exp_ptr = '0; exp_state = 3'd0;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hA5A5_0000 ^ 32'(i * 32'h0101_0013);
      emem[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(rx_state === 3'd0, "R9", "reset state", {29'd0, rx_state}, 0);
    chk(desc_ptr === '0, "R1", "reset pointer", desc_ptr, 0);
    chk(!ev_ri && !ev_ru && frm_idle, "R8", "reset events", {30'd0, ev_ri, ev_ru}, 0);

    // single buffer, pointer loaded from base
    setd(32'h100, 32'h8000_0000, 32'd30, 32'h400, 32'h0);
    run_frame(9, 1);
    chk(mem[32'h100 >> 2] === 32'h000D_0300, "R6 R3", "single descriptor word0",
        mem[32'h100 >> 2], 32'h000D_0300);
    chk(desc_ptr === 32'h110, "R1", "pointer after first frame", desc_ptr, 32'h110);

    // two buffers of odd size then a second descriptor
    setd(32'h110, 32'h8000_0000, 32'd5 | (32'd7 << 11), 32'h500, 32'h520);
    setd(32'h120, 32'h8000_0000, 32'd16, 32'h540, 32'h0);
    run_frame(20, 1);
    chk(mem[32'h110 >> 2] === 32'h000C_0200, "R4 R6", "first of two word0",
        mem[32'h110 >> 2], 32'h000C_0200);
    chk(mem[32'h120 >> 2] === 32'h0018_0100, "R4 R6", "last of two word0",
        mem[32'h120 >> 2], 32'h0018_0100);

    // chained then end-of-ring wins over chained
    setd(32'h130, 32'h8000_0000, (32'd1 << 24) | 32'd6, 32'h580, 32'h200);
    setd(32'h200, 32'h8000_0000, (32'd1 << 25) | (32'd1 << 24) | 32'd40, 32'h600, 32'h300);
    run_frame(10, 1);
    chk(desc_ptr === BASE, "R5", "end-of-ring over chained", desc_ptr, BASE);

    // first descriptor not owned
    setd(32'h100, 32'h0000_0000, 32'd30, 32'h400, 32'h0);
    run_frame(7, 0);
    chk(rx_state === 3'd4, "R2", "suspended code", {29'd0, rx_state}, 4);

    // mid-frame unowned without flush
    setd(32'h100, 32'h8000_0000, 32'd4, 32'h400, 32'h0);
    setd(32'h110, 32'h0000_0000, 32'd0, 32'h0, 32'h0);
    run_frame(10, 0);
    chk(mem[32'h110 >> 2] === 32'h0004_4100, "R7", "error descriptor word0",
        mem[32'h110 >> 2], 32'h0004_4100);

    // mid-frame unowned with flush, interrupt disabled
    cfg_flush = 1'b1;
    setd(32'h120, 32'h8000_0000, 32'd3 | (32'd2 << 11), 32'h540, 32'h560);
    setd(32'h130, 32'h0000_0000, (32'd1 << 31) | (32'd1 << 25), 32'h0, 32'h0);
    run_frame(10, 0);
    chk(mem[32'h130 >> 2] === 32'h0005_0100, "R7", "flush descriptor word0",
        mem[32'h130 >> 2], 32'h0005_0100);
    chk(desc_ptr === BASE, "R5 R8", "wrap after flush", desc_ptr, BASE);
    cfg_flush = 1'b0;

    // random frames over a re-armed ring
    for (int f = 0; f < 40; f++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] w1;
        w1 = 32'($urandom_range(0, 24)) | (32'($urandom_range(0, 24)) << 11)
           | ((k == 3) ? (32'd1 << 25) : 32'd0)
           | (($urandom_range(0, 3) == 0) ? (32'd1 << 31) : 32'd0);
        setd(BASE + 32'(16 * k), 32'h8000_0000, w1, 32'h400 + 32'(k * 256),
             32'h480 + 32'(k * 256));
      end
      cfg_flush = ($urandom_range(0, 1) == 1);
      run_frame($urandom_range(1, 60), 0);
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule